// File: doc/BRIEF.md
# Interleaved Misaligned Instruction Fetch Unit

This block returns four consecutive instructions per request from a word-granular fetch address. The address may point at any position inside a cache row. The instruction storage is split into four column banks. Each bank holds one instruction of every row and chooses its read row on its own. A bank whose column lies before the fetch offset reads the row after the addressed one. A group that runs past the end of a row is therefore read out whole in a single access.

A rotation network places the four bank outputs in program order. A tag array reports hit or miss. It checks the addressed row and, when the group crosses into the next row, that row as well. A fill port writes one complete row, its tag and its valid bit in one cycle.

A control state machine has two states. `ST_IDLE` means no response is presented. `ST_RESP` means a registered response is presented. The transition `IDLE->RESP` and the transition `RESP->RESP` are taken on a cycle with a request. The transition `RESP->IDLE` and the transition `IDLE->IDLE` are taken on a cycle without one.

Top module: `ilv_fetch_unit`

## Requirements
- R1: `rsp_vld` is high in exactly the cycle after a cycle in which `req_vld` was high. `rsp_hit` and `rsp_words` are valid in that same cycle.
- R2: `req_addr` is laid out as {tag, row, offset}. The offset is the 2 least significant bits and selects the column. The row field sits above it, and the tag takes the remaining upper bits.
- R3: A bank whose column index is greater than or equal to the offset supplies the word from the addressed row.
- R4: A bank whose column index is less than the offset supplies the word from the following row. Past the last row, the following row is row 0.
- R5: `rsp_words[i*WORD_W +: WORD_W]` is the instruction at word address `req_addr + i`, for i = 0..3. Row and column wrap together across the whole array.
- R6: `rsp_hit` requires the addressed row to be valid and its stored tag to equal the request tag.
- R7: When the offset is nonzero, `rsp_hit` also requires the following row to be valid with a stored tag equal to the tag of `req_addr + 4`. That tag is the request tag plus one when the addressed row is the last row.
- R8: Reset clears every valid bit and drives `rsp_vld` and `rsp_hit` low.
- R9: With `fill_en` high, the row `fill_row` takes `fill_words[j*WORD_W +: WORD_W]` into column j, stores `fill_tag`, and becomes valid. A request in the same cycle sees the previous contents. Requests from the next cycle on see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Fetch request strobe |
| req_addr | input | TAG_W+log2(ROWS)+2 | Word address {tag, row, offset} |
| fill_en | input | 1 | Row write strobe |
| fill_row | input | log2(ROWS) | Row to write |
| fill_tag | input | TAG_W | Tag stored with the row |
| fill_words | input | 4*WORD_W | Column j data at bits j*WORD_W |
| rsp_vld | output | 1 | Response present |
| rsp_hit | output | 1 | All involved tags matched and were valid |
| rsp_words | output | 4*WORD_W | Four instructions in program order |

## Verification
Every fetch result is due one clock edge after the request edge. This covers `rsp_vld`, `rsp_hit` and all four words. The bench drives a request on a falling edge and lowers it on the next falling edge. It reads the outputs at that second falling edge, after the single capturing register has loaded.

A fill takes effect at the edge that samples it. A request at that same edge must return the old row, and the next request must return the new one. The bench checks both cases with the same one-cycle spacing. It also looks at `rsp_vld` in a cycle with no preceding request, where it must be low.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int LANES = 4;
    localparam int OFF_W = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/fetch_col_bank.sv
module fetch_col_bank #(
    parameter int ROWS   = 8,
    parameter int WORD_W = 32,
    parameter int COL    = 0,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_row,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_row,
    input  logic [fetch_pkg::OFF_W-1:0] rd_off,
    output logic [WORD_W-1:0] rd_word,
    output logic [IDX_W-1:0]  sel_row
);
    localparam logic [fetch_pkg::OFF_W-1:0] COL_V = fetch_pkg::OFF_W'(COL);
    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    logic [WORD_W-1:0] store [ROWS];

    // Row steering: columns ahead of the offset belong to the next row.
    always_comb begin
        if (COL_V < rd_off) begin
            sel_row = (rd_row == LAST_ROW) ? '0 : rd_row + 1'b1;
        end else begin
            sel_row = rd_row;
        end
        rd_word = store[sel_row];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_row] <= wr_word;
        end
    end

    // R3 / R4: this bank only leaves the addressed row when it sits before the offset
    always_comb begin
        a_r4_next_row_only_low_cols: assert ((sel_row == rd_row) || (COL_V < rd_off));
        a_r3_same_row_at_or_after: assert ((COL_V < rd_off) || (sel_row == rd_row));
    end
endmodule

// File: rtl/fetch_tag_array.sv
module fetch_tag_array #(
    parameter int ROWS  = 8,
    parameter int TAG_W = 6,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_row_a,
    input  logic [IDX_W-1:0] rd_row_b,
    output logic [TAG_W-1:0] tag_a,
    output logic             vld_a,
    output logic [TAG_W-1:0] tag_b,
    output logic             vld_b
);
    logic [TAG_W-1:0] tags [ROWS];
    logic [ROWS-1:0]  vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_row] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_row] <= wr_tag;
        end
    end

    always_comb begin
        tag_a = tags[rd_row_a];
        vld_a = vld_q[rd_row_a];
        tag_b = tags[rd_row_b];
        vld_b = vld_q[rd_row_b];
    end

    // R9: a filled row is valid from the next cycle on
    a_r9_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_row)]);
    // R8: valid bits only ever get set by a fill
    a_r8_valid_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/fetch_rotator.sv
module fetch_rotator #(
    parameter int WORD_W = 32
) (
    input  logic [fetch_pkg::OFF_W-1:0]          off,
    input  logic [fetch_pkg::LANES*WORD_W-1:0]   bank_words,
    output logic [fetch_pkg::LANES*WORD_W-1:0]   prog_words
);
    import fetch_pkg::*;

    for (genvar i = 0; i < LANES; i++) begin : g_slot
        logic [OFF_W-1:0] src;
        assign src = off + OFF_W'(i);
        assign prog_words[i*WORD_W +: WORD_W] = bank_words[src*WORD_W +: WORD_W];
    end

    // R5: a zero offset leaves the bank order untouched
    always_comb begin
        if (off == '0) begin
            a_r5_zero_off_identity: assert (prog_words == bank_words);
        end
    end
endmodule

// File: rtl/ilv_fetch_unit.sv
module ilv_fetch_unit #(
    parameter int ROWS   = 8,
    parameter int WORD_W = 32,
    parameter int TAG_W  = 6,
    localparam int IDX_W = $clog2(ROWS),
    localparam int AW    = TAG_W + IDX_W + fetch_pkg::OFF_W,
    localparam int DW    = fetch_pkg::LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [AW-1:0]    req_addr,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_row,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DW-1:0]    fill_words,
    output logic             rsp_vld,
    output logic             rsp_hit,
    output logic [DW-1:0]    rsp_words
);
    import fetch_pkg::*;

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    // Address fields
    logic [OFF_W-1:0] a_off;
    logic [IDX_W-1:0] a_row;
    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_row_nxt;
    logic [TAG_W-1:0] a_tag_nxt;

    always_comb begin
        a_off     = req_addr[OFF_W-1:0];
        a_row     = req_addr[OFF_W +: IDX_W];
        a_tag     = req_addr[AW-1 -: TAG_W];
        a_row_nxt = (a_row == LAST_ROW) ? '0 : a_row + 1'b1;
        a_tag_nxt = (a_row == LAST_ROW) ? a_tag + 1'b1 : a_tag;
    end

    // Column banks
    logic [DW-1:0] bank_words;

    for (genvar j = 0; j < LANES; j++) begin : g_bank
        logic [IDX_W-1:0] sel_row;
        fetch_col_bank #(
            .ROWS   (ROWS),
            .WORD_W (WORD_W),
            .COL    (j)
        ) u_bank (
            .clk     (clk),
            .wr_en   (fill_en),
            .wr_row  (fill_row),
            .wr_word (fill_words[j*WORD_W +: WORD_W]),
            .rd_row  (a_row),
            .rd_off  (a_off),
            .rd_word (bank_words[j*WORD_W +: WORD_W]),
            .sel_row (sel_row)
        );
    end

    // Reorder into program order
    logic [DW-1:0] prog_words;

    fetch_rotator #(.WORD_W(WORD_W)) u_rot (
        .off        (a_off),
        .bank_words (bank_words),
        .prog_words (prog_words)
    );

    // Tags
    logic [TAG_W-1:0] tag_a, tag_b;
    logic             vld_a, vld_b;

    fetch_tag_array #(.ROWS(ROWS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_en),
        .wr_row   (fill_row),
        .wr_tag   (fill_tag),
        .rd_row_a (a_row),
        .rd_row_b (a_row_nxt),
        .tag_a    (tag_a),
        .vld_a    (vld_a),
        .tag_b    (tag_b),
        .vld_b    (vld_b)
    );

    logic hit_first, hit_second, hit_c;

    always_comb begin
        hit_first  = vld_a && (tag_a == a_tag);
        hit_second = (a_off == '0) || (vld_b && (tag_b == a_tag_nxt));
        hit_c      = hit_first && hit_second;
    end

    // Response state machine
    rsp_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_vld ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_vld ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    logic hit_q;
    logic [DW-1:0] words_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= req_vld && hit_c;
        end
    end

    always_ff @(posedge clk) begin
        if (req_vld) begin
            words_q <= prog_words;
        end
    end

    always_comb begin
        rsp_vld   = (state_q == ST_RESP);
        rsp_hit   = hit_q;
        rsp_words = words_q;
    end

    // R1: response follows a request by exactly one cycle
    a_r1_resp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    a_r1_no_resp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);
    // R6: a hit is only ever reported alongside a response
    a_r6_hit_needs_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_vld);
    // R7: a crossing group cannot hit when the following row is invalid
    a_r7_second_row_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (a_off != '0) && !vld_b) |=> !rsp_hit);
endmodule

// File: tb/tb_ilv_fetch_unit.sv
`timescale 1ns/1ps
module tb_ilv_fetch_unit;
    localparam int ROWS   = 8;
    localparam int WORD_W = 32;
    localparam int TAG_W  = 6;
    localparam int IDX_W  = 3;
    localparam int AW     = TAG_W + IDX_W + 2;
    localparam int DW     = 4 * WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic fill_en = 1'b0;
    logic [IDX_W-1:0] fill_row = '0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic [DW-1:0] fill_words = '0;
    logic rsp_vld, rsp_hit;
    logic [DW-1:0] rsp_words;

    always #2.5 clk = ~clk;

    ilv_fetch_unit #(.ROWS(ROWS), .WORD_W(WORD_W), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .fill_en(fill_en), .fill_row(fill_row), .fill_tag(fill_tag),
        .fill_words(fill_words), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
        .rsp_words(rsp_words)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference contents
    logic [WORD_W-1:0] m_word [ROWS][4];
    logic [TAG_W-1:0]  m_tag  [ROWS];
    logic              m_vld  [ROWS];

    function automatic logic [WORD_W-1:0] pattern(int gen, int tag, int row, int col);
        return 32'hA500_0000 ^ WORD_W'(gen << 20) ^ WORD_W'(tag << 12)
             ^ WORD_W'(row << 4) ^ WORD_W'(col);
    endfunction

    task automatic fill(int row, int tag, int gen);
        @(negedge clk);
        fill_en  = 1'b1;
        fill_row = IDX_W'(row);
        fill_tag = TAG_W'(tag);
        for (int j = 0; j < 4; j++) begin
            fill_words[j*WORD_W +: WORD_W] = pattern(gen, tag, row, j);
            m_word[row][j] = pattern(gen, tag, row, j);
        end
        m_tag[row] = TAG_W'(tag);
        m_vld[row] = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic check(string req, logic [DW-1:0] act_w, logic [DW-1:0] exp_w,
                         logic act_h, logic exp_h, logic act_v);
        checks++;
        if (act_w !== exp_w || act_h !== exp_h || act_v !== 1'b1) begin
            fails++;
            $display("FAIL %s: vld=%0b hit=%0b words=%h, expected vld=1 hit=%0b words=%h",
                     req, act_v, act_h, act_w, exp_h, exp_w);
        end
    endtask

    // Expected response from the reference contents (R2, R5, R6, R7)
    task automatic expect_of(int tag, int row, int off,
                             output logic [DW-1:0] ew, output logic eh);
        int base;
        int r1;
        int t2;
        base = row * 4 + off;
        for (int i = 0; i < 4; i++) begin
            int a;
            a = (base + i) % (ROWS * 4);
            ew[i*WORD_W +: WORD_W] = m_word[a / 4][a % 4];
        end
        r1 = (row + 1) % ROWS;
        t2 = (row == ROWS - 1) ? ((tag + 1) % (1 << TAG_W)) : tag;
        eh = m_vld[row] && (m_tag[row] == TAG_W'(tag))
             && (off == 0 || (m_vld[r1] && m_tag[r1] == TAG_W'(t2)));
    endtask

    task automatic fetch(string req, int tag, int row, int off);
        logic [DW-1:0] ew;
        logic eh;
        expect_of(tag, row, off, ew, eh);
        @(negedge clk);
        req_vld  = 1'b1;
        req_addr = {TAG_W'(tag), IDX_W'(row), 2'(off)};
        @(negedge clk);
        req_vld = 1'b0;
        check(req, rsp_words, ew, rsp_hit, eh, rsp_vld);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog R1: cycles=%0d expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++) begin
            m_vld[r] = 1'b0;
            m_tag[r] = '0;
            for (int j = 0; j < 4; j++) m_word[r][j] = '0;
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (rsp_vld !== 1'b0 || rsp_hit !== 1'b0) begin
            fails++;
            $display("FAIL R8: vld=%0b hit=%0b, expected 0 0", rsp_vld, rsp_hit);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R8: nothing valid after reset, so any fetch misses
        begin
            logic [DW-1:0] ew;
            logic eh;
            expect_of(5, 3, 0, ew, eh);
            @(negedge clk);
            req_vld = 1'b1;
            req_addr = {TAG_W'(5), IDX_W'(3), 2'd0};
            @(negedge clk);
            req_vld = 1'b0;
            checks++;
            if (rsp_vld !== 1'b1 || rsp_hit !== 1'b0) begin
                fails++;
                $display("FAIL R8: vld=%0b hit=%0b, expected 1 0", rsp_vld, rsp_hit);
            end
        end
        // R1: no request in the previous cycle -> no response
        @(negedge clk);
        checks++;
        if (rsp_vld !== 1'b0 || rsp_hit !== 1'b0) begin
            fails++;
            $display("FAIL R1: idle vld=%0b hit=%0b, expected 0 0", rsp_vld, rsp_hit);
        end

        // R9: fill every row with tag 5
        for (int r = 0; r < ROWS; r++) fill(r, 5, 1);

        // R3 R4 R5 R6 R7: sweep every row and offset (row 7 crossing misses on tag)
        for (int r = 0; r < ROWS; r++)
            for (int o = 0; o < 4; o++)
                fetch("R3/R4/R5/R7 sweep tag5", 5, r, o);

        // R6: wrong tag misses
        for (int o = 0; o < 4; o++) fetch("R6 wrong tag", 9, 2, o);

        // R7: row 0 now holds tag 6, so crossing from row 7 with tag 5 hits
        fill(0, 6, 2);
        for (int o = 0; o < 4; o++) fetch("R4/R7 wrap to row0", 5, ROWS - 1, o);
        for (int o = 0; o < 4; o++) fetch("R6 row0 retagged", 5, 0, o);
        fetch("R7 row6 crossing", 5, 6, 3);

        // R9: request in the fill cycle sees old data, next sees new
        begin
            logic [DW-1:0] ew;
            logic eh;
            expect_of(5, 4, 1, ew, eh);
            @(negedge clk);
            fill_en  = 1'b1;
            fill_row = IDX_W'(4);
            fill_tag = TAG_W'(5);
            for (int j = 0; j < 4; j++)
                fill_words[j*WORD_W +: WORD_W] = pattern(3, 5, 4, j);
            req_vld  = 1'b1;
            req_addr = {TAG_W'(5), IDX_W'(4), 2'd1};
            @(negedge clk);
            fill_en = 1'b0;
            req_vld = 1'b0;
            check("R9 same-cycle old data", rsp_words, ew, rsp_hit, eh, rsp_vld);
            for (int j = 0; j < 4; j++) m_word[4][j] = pattern(3, 5, 4, j);
        end
        for (int o = 0; o < 4; o++) fetch("R9 new data visible", 5, 4, o);
        fetch("R5 crossing into refilled row", 5, 3, 2);

        // R1: back-to-back requests each answered in the following cycle
        begin
            logic [DW-1:0] e1, e2;
            logic h1, h2;
            expect_of(5, 1, 2, e1, h1);
            expect_of(5, 2, 3, e2, h2);
            @(negedge clk);
            req_vld = 1'b1;
            req_addr = {TAG_W'(5), IDX_W'(1), 2'd2};
            @(negedge clk);
            req_addr = {TAG_W'(5), IDX_W'(2), 2'd3};
            check("R1 back-to-back first", rsp_words, e1, rsp_hit, h1, rsp_vld);
            @(negedge clk);
            req_vld = 1'b0;
            check("R1 back-to-back second", rsp_words, e2, rsp_hit, h2, rsp_vld);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule